// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests that arrive as small unsigned codes and keeps one pending bit for each code, so requests that arrive together are not lost. Each cycle it picks the most urgent request that may run now and holds its code in an interrupt register, independently of what the processor is doing. When the processor signals the end of an execute cycle with a boundary strobe and that register is nonzero, the block issues a one-cycle branch request together with the code and the handler start address. The address comes from a vector table that software writes through a simple write port.

A smaller code is more urgent, and code 0 means "nothing". The block keeps a stack of the levels in service. A request more urgent than the running handler is dispatched at the next boundary and nests on top of it. A request of equal or lower urgency waits until the handlers above it have finished. An end-of-handler pulse pops the current level and restores the previous one as the threshold for preemption. Saving machine state and the processor pipeline are outside this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A request with `req_valid` high and a nonzero `req_code` sets that code's pending bit. Two clocks after the request, `irq_code` shows the most urgent eligible pending code, with no boundary strobe needed. A request carrying code 0 has no effect.
- R2: `branch_req` is a one-cycle pulse on the clock after a cycle in which `boundary` was high and `irq_code` was nonzero. `branch_code` then equals the code held in that cycle. Without a boundary strobe no branch is requested.
- R3: `branch_addr`, valid together with `branch_req`, is the value most recently written to the vector table entry whose index equals `branch_code`.
- R4: On the clock that raises `branch_req`, `irq_code` becomes 0 and the dispatched code's pending bit is cleared, so that code is not dispatched again unless it is requested again.
- R5: When several codes are pending and eligible, the numerically smallest one is selected.
- R6: A pending code greater than or equal to `svc_code` is not shown in `irq_code` while that level is in service. It becomes eligible once the levels in front of it have retired.
- R7: A pending code smaller than `svc_code` is dispatched at the next boundary. `nest_depth` rises by one and `svc_code` becomes the new code.
- R8: An `eoh` pulse with a nonempty stack lowers `nest_depth` by one and restores `svc_code` to the level below, or to 0 when the stack becomes empty. An `eoh` pulse with an empty stack has no effect.
- R9: While `nest_depth` equals the stack depth, no branch is requested. The pending code waits and is dispatched after a retirement frees a slot.
- R10: A boundary strobe in the same cycle as `eoh` dispatches nothing in that cycle.
- R11: After a synchronous reset, `branch_req` is 0 and `irq_code`, `svc_code` and `nest_depth` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for `req_code` |
| req_code | input | CODE_W | Requested interrupt code (0 = none) |
| boundary | input | 1 | End-of-execute-cycle strobe from the processor |
| eoh | input | 1 | End-of-handler pulse that retires the current level |
| vec_we | input | 1 | Vector table write enable |
| vec_waddr | input | CODE_W | Vector table entry to write |
| vec_wdata | input | ADDR_W | Handler start address to store |
| branch_req | output | 1 | One-cycle request to branch to the supervisor |
| branch_code | output | CODE_W | Code being dispatched |
| branch_addr | output | ADDR_W | Handler start address for `branch_code` |
| irq_code | output | CODE_W | Interrupt register: eligible code waiting for a boundary |
| svc_code | output | CODE_W | Code currently in service (0 = none) |
| nest_depth | output | DEPTH_W | Number of nested levels in service |

## Verification
The bench builds the block with 8 codes, a three-deep nesting stack and 12-bit handler addresses. With only eight codes, every nonzero code can be swept through request, dispatch, address lookup and retirement. With only three stack slots, a chain of preemptions (7, then 6, then 5) fills the stack and shows that a more urgent fourth request is held back until a retirement frees a slot. Equal-code requests, the same-cycle boundary and end-of-handler case, and a rewritten vector entry cover the remaining orderings.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned NIC_CODES_DFLT  = 16;
  localparam int unsigned NIC_DEPTH_DFLT  = 4;
  localparam int unsigned NIC_ADDR_W_DFLT = 16;
endpackage

// File: rtl/nic_pend_latch.sv
module nic_pend_latch #(
  parameter int NUM_CODES = 16,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              clr,
  input  logic [CODE_W-1:0] clr_code,
  input  logic              thr_open,
  input  logic [CODE_W-1:0] thr_code,
  output logic [CODE_W-1:0] irq_q
);
  logic [NUM_CODES-1:0] pend_q, pend_d;
  logic [CODE_W-1:0]    best;

  // next state of each pending bit; a new request wins over a clear
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_bit
    if (g == 0) begin : g_null
      assign pend_d[g] = 1'b0;
    end else begin : g_code
      assign pend_d[g] = (req_valid && req_code == CODE_W'(g)) ||
                         (pend_q[g] && !(clr && clr_code == CODE_W'(g)));
    end
  end

  // smallest eligible code wins: scan downward so the last hit is the lowest
  always_comb begin
    best = '0;
    for (int c = NUM_CODES - 1; c >= 1; c--) begin
      if (pend_q[c] && (thr_open || CODE_W'(c) < thr_code)) best = CODE_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= clr ? '0 : best;
    end
  end
endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack #(
  parameter int CODE_W  = 4,
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [CODE_W-1:0]  push_code,
  input  logic               pop,
  output logic [CODE_W-1:0]  top_code,
  output logic               empty,
  output logic               full,
  output logic [DEPTH_W-1:0] level
);
  logic [DEPTH_W-1:0] sp_q;
  logic [CODE_W-1:0]  slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                  slot_q[g] <= '0;
      else if (push && sp_q == DEPTH_W'(g))     slot_q[g] <= push_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                sp_q <= '0;
    else if (push && !full) sp_q <= sp_q + DEPTH_W'(1);
    else if (pop && !empty) sp_q <= sp_q - DEPTH_W'(1);
  end

  always_comb begin
    top_code = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == DEPTH_W'(i + 1)) top_code = slot_q[i];
    end
  end

  assign empty = (sp_q == '0);
  assign full  = (sp_q == DEPTH_W'(DEPTH));
  assign level = sp_q;
endmodule

// File: rtl/nic_vec_table.sv
module nic_vec_table #(
  parameter int NUM_CODES = 16,
  parameter int CODE_W    = 4,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              re,
  input  logic [CODE_W-1:0] raddr,
  output logic [ADDR_W-1:0] rd_q
);
  logic [ADDR_W-1:0] mem [NUM_CODES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= mem[raddr];
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_CODES = NIC_CODES_DFLT,
  parameter int DEPTH     = NIC_DEPTH_DFLT,
  parameter int ADDR_W    = NIC_ADDR_W_DFLT,
  localparam int CODE_W   = $clog2(NUM_CODES),
  localparam int DEPTH_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [CODE_W-1:0]  req_code,
  input  logic               boundary,
  input  logic               eoh,
  input  logic               vec_we,
  input  logic [CODE_W-1:0]  vec_waddr,
  input  logic [ADDR_W-1:0]  vec_wdata,
  output logic               branch_req,
  output logic [CODE_W-1:0]  branch_code,
  output logic [ADDR_W-1:0]  branch_addr,
  output logic [CODE_W-1:0]  irq_code,
  output logic [CODE_W-1:0]  svc_code,
  output logic [DEPTH_W-1:0] nest_depth
);
  logic [CODE_W-1:0]  irq_q, top_code;
  logic               stk_empty, stk_full, dispatch, retire;
  logic [DEPTH_W-1:0] lvl;

  // a retirement in the same cycle takes precedence; dispatch waits
  assign dispatch = boundary && (irq_q != '0) && !stk_full && !eoh;
  assign retire   = eoh && !stk_empty;

  nic_pend_latch #(.NUM_CODES(NUM_CODES), .CODE_W(CODE_W)) pend_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .clr(dispatch), .clr_code(irq_q), .thr_open(stk_empty),
    .thr_code(top_code), .irq_q(irq_q)
  );

  nic_nest_stack #(.CODE_W(CODE_W), .DEPTH(DEPTH), .DEPTH_W(DEPTH_W)) stk_i (
    .clk(clk), .rst(rst), .push(dispatch), .push_code(irq_q), .pop(retire),
    .top_code(top_code), .empty(stk_empty), .full(stk_full), .level(lvl)
  );

  nic_vec_table #(.NUM_CODES(NUM_CODES), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) vec_i (
    .clk(clk), .rst(rst), .we(vec_we), .waddr(vec_waddr), .wdata(vec_wdata),
    .re(dispatch), .raddr(irq_q), .rd_q(branch_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      branch_req  <= 1'b0;
      branch_code <= '0;
    end else begin
      branch_req <= dispatch;
      if (dispatch) branch_code <= irq_q;
    end
  end

  assign irq_code   = irq_q;
  assign svc_code   = top_code;
  assign nest_depth = lvl;
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int CODE_W  = 4,
  parameter int DEPTH_W = 3,
  parameter int DEPTH   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               boundary,
  input logic               eoh,
  input logic               branch_req,
  input logic [CODE_W-1:0]  branch_code,
  input logic [CODE_W-1:0]  irq_code,
  input logic [CODE_W-1:0]  svc_code,
  input logic [DEPTH_W-1:0] nest_depth
);
  p_branch_cause_r2: assert property (@(posedge clk) disable iff (rst)
    branch_req |-> ($past(boundary) && $past(irq_code) != '0));
  p_branch_code_r2: assert property (@(posedge clk) disable iff (rst)
    branch_req |-> branch_code == $past(irq_code));
  p_irq_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    branch_req |-> irq_code == '0);
  p_preempt_lower_r7: assert property (@(posedge clk) disable iff (rst)
    (branch_req && $past(nest_depth) != '0) |-> branch_code < $past(svc_code));
  p_push_depth_r7: assert property (@(posedge clk) disable iff (rst)
    branch_req |-> nest_depth == $past(nest_depth) + DEPTH_W'(1));
  p_pop_depth_r8: assert property (@(posedge clk) disable iff (rst)
    (eoh && nest_depth != '0) |=> nest_depth == $past(nest_depth) - DEPTH_W'(1));
  p_depth_cap_r9: assert property (@(posedge clk) disable iff (rst)
    nest_depth <= DEPTH_W'(DEPTH));
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    branch_req |-> $past(nest_depth) < DEPTH_W'(DEPTH));
  p_eoh_defers_r10: assert property (@(posedge clk) disable iff (rst)
    branch_req |-> !$past(eoh));
endmodule

bind nest_irq_ctrl nic_chk #(.CODE_W(CODE_W), .DEPTH_W(DEPTH_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .boundary(boundary), .eoh(eoh), .branch_req(branch_req),
  .branch_code(branch_code), .irq_code(irq_code), .svc_code(svc_code),
  .nest_depth(nest_depth)
);

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;
  localparam int NC = 8, DP = 3, AW = 12, CW = 3, DW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, boundary = 1'b0, eoh = 1'b0, vec_we = 1'b0;
  logic [CW-1:0] req_code = '0, vec_waddr = '0;
  logic [AW-1:0] vec_wdata = '0;
  logic branch_req;
  logic [CW-1:0] branch_code, irq_code, svc_code;
  logic [AW-1:0] branch_addr;
  logic [DW-1:0] nest_depth;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  nest_irq_ctrl #(.NUM_CODES(NC), .DEPTH(DP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .boundary(boundary), .eoh(eoh), .vec_we(vec_we), .vec_waddr(vec_waddr),
    .vec_wdata(vec_wdata), .branch_req(branch_req), .branch_code(branch_code),
    .branch_addr(branch_addr), .irq_code(irq_code), .svc_code(svc_code),
    .nest_depth(nest_depth)
  );

  function automatic int vexp(input int c);
    return (256 + c * 37) & 12'hFFF;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wr(input int c, input int v);
    vec_we = 1'b1; vec_waddr = CW'(c); vec_wdata = AW'(v);
    step();
    vec_we = 1'b0;
  endtask

  // request, then wait until the interrupt register reflects it
  task automatic raise(input int c);
    req_valid = 1'b1; req_code = CW'(c);
    step();
    req_valid = 1'b0;
    step();
  endtask

  // boundary strobe; returns with branch outputs valid
  task automatic fire();
    boundary = 1'b1;
    step();
    boundary = 1'b0;
  endtask

  // end of handler, then one more cycle for the register to recompute
  task automatic done();
    eoh = 1'b1;
    step();
    eoh = 1'b0;
    step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    chk("R11 branch_req after reset", int'(branch_req), 0);
    chk("R11 irq_code after reset", int'(irq_code), 0);
    chk("R11 svc_code after reset", int'(svc_code), 0);
    chk("R11 nest_depth after reset", int'(nest_depth), 0);

    for (int c = 1; c < NC; c++) wr(c, vexp(c));

    // sweep every code through a full single-level cycle
    for (int c = 1; c < NC; c++) begin
      raise(c);
      chk("R1 irq_code latched", int'(irq_code), c);
      chk("R2 no branch without boundary", int'(branch_req), 0);
      fire();
      chk("R2 branch_req pulse", int'(branch_req), 1);
      chk("R2 branch_code", int'(branch_code), c);
      chk("R3 branch_addr", int'(branch_addr), vexp(c));
      chk("R4 irq_code cleared", int'(irq_code), 0);
      chk("R7 svc_code", int'(svc_code), c);
      chk("R7 depth one", int'(nest_depth), 1);
      step();
      chk("R2 pulse one cycle", int'(branch_req), 0);
      done();
      chk("R8 depth back to zero", int'(nest_depth), 0);
      chk("R4 no re-dispatch", int'(irq_code), 0);
    end

    // code 0 is ignored
    raise(0);
    chk("R1 code zero ignored", int'(irq_code), 0);
    fire();
    chk("R2 no branch for empty register", int'(branch_req), 0);

    // simultaneous pending requests, lowest wins, others wait
    raise(5); raise(3); raise(6);
    chk("R5 lowest code selected", int'(irq_code), 3);
    fire();
    chk("R5 dispatched lowest", int'(branch_code), 3);
    step();
    chk("R6 higher codes held", int'(irq_code), 0);
    fire();
    chk("R6 no branch while held", int'(branch_req), 0);
    done();
    chk("R8 svc restored to none", int'(svc_code), 0);
    chk("R6 next code after retire", int'(irq_code), 5);
    fire();
    chk("R6 dispatch 5", int'(branch_code), 5);
    done();
    chk("R6 then 6", int'(irq_code), 6);
    fire();
    chk("R6 dispatch 6", int'(branch_code), 6);
    done();

    // preemption and restore
    raise(6); fire();
    raise(2);
    chk("R7 preempting code visible", int'(irq_code), 2);
    fire();
    chk("R7 preempt branch", int'(branch_req), 1);
    chk("R7 preempt code", int'(branch_code), 2);
    chk("R7 depth two", int'(nest_depth), 2);
    chk("R7 svc is new level", int'(svc_code), 2);
    done();
    chk("R8 svc restored", int'(svc_code), 6);
    chk("R8 depth one", int'(nest_depth), 1);
    done();
    chk("R8 empty again", int'(nest_depth), 0);

    // equal code is not eligible
    raise(4); fire();
    raise(4);
    chk("R6 equal code held", int'(irq_code), 0);
    done();
    chk("R6 equal code after retire", int'(irq_code), 4);
    fire();
    chk("R6 equal code dispatched", int'(branch_code), 4);
    done();

    // full stack blocks dispatch
    raise(7); fire(); raise(6); fire(); raise(5); fire();
    chk("R9 stack full depth", int'(nest_depth), 3);
    raise(1);
    chk("R9 urgent code waits in register", int'(irq_code), 1);
    fire();
    chk("R9 no branch when full", int'(branch_req), 0);
    chk("R9 depth unchanged", int'(nest_depth), 3);
    done();
    chk("R8 pop from full", int'(svc_code), 6);
    fire();
    chk("R9 dispatch after slot frees", int'(branch_code), 1);
    chk("R9 branch raised", int'(branch_req), 1);
    done(); done(); done();
    chk("R8 drained", int'(nest_depth), 0);

    // eoh on empty stack
    done();
    chk("R8 eoh on empty ignored", int'(nest_depth), 0);
    chk("R8 svc stays none", int'(svc_code), 0);

    // boundary together with eoh
    raise(4);
    boundary = 1'b1; eoh = 1'b1;
    step();
    boundary = 1'b0; eoh = 1'b0;
    chk("R10 no dispatch with eoh", int'(branch_req), 0);
    chk("R10 register kept", int'(irq_code), 4);
    fire();
    chk("R10 dispatch next boundary", int'(branch_code), 4);
    done();

    // rewritten vector entry
    wr(2, 12'hABC);
    raise(2); fire();
    chk("R3 rewritten address", int'(branch_addr), 12'hABC);
    done();

    summary();
    $finish;
  end
endmodule